// File: doc/BRIEF.md
# Secured-Sector Protect Verify Sequencer

This block is a host-side controller that finds out whether the one-time-programmable secured sector of an attached flash device has been locked. One pulse on `start_i` runs a fixed procedure. It raises the enable for the high-voltage level on the flash reset pin. It waits a settling time given in clock cycles. It writes an entry command and then a verify command, and reads back a status byte. It then drops the high voltage and writes a reset command so that the flash returns to array read.

The flash bus is an abstract request/acknowledge port. A request holds its address, data and direction until the acknowledge arrives, and read data is taken in the acknowledge cycle. The verdict is given on `prot_o` and `err_o`, together with a one-cycle `done_o`. Both results stay valid until the next run starts. The pin timing and the generation of the high voltage belong to the bus agent and are not part of this block.

Top module: `otp_guard_verify`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `hv_en_o`, `bus_req_o`, `prot_o` and `err_o` are all low.
- R2: A `start_i` pulse while idle makes `hv_en_o` and `busy_o` high from the next cycle, and clears `prot_o` and `err_o`.
- R3: After `hv_en_o` rises, no bus request is issued for exactly `WAIT_CYCLES` clock cycles.
- R4: The first bus operation is a write (`bus_we_o`=1) of data 0x60 to address `CMD_ADDR`.
- R5: The second bus operation is a write of 0x40 to the verify address. This address is `SEC_ADDR` with bit 6 forced to 0, bit 1 forced to 1 and bit 0 forced to 0 (12'hAC5 gives 12'hA86).
- R6: The third bus operation is a read (`bus_we_o`=0) from the same verify address, with `hv_en_o` still high.
- R7: A status byte of 0x01 gives `prot_o`=1 and `err_o`=0. A status byte of 0x00 gives `prot_o`=0 and `err_o`=0.
- R8: Any other status byte gives `err_o`=1 and `prot_o`=0, and the remaining cleanup operations still run.
- R9: `hv_en_o` is low from the cycle after the read is acknowledged. The fourth operation is a write of 0xF0 to `CMD_ADDR`, made with `hv_en_o` low.
- R10: `done_o` is high for exactly one cycle, the cycle after the 0xF0 write is acknowledged, and `busy_o` is low in that cycle. `prot_o` and `err_o` hold their values until the next start.
- R11: `start_i` has no effect while `busy_o` is high. The run in progress keeps its order of operations and produces a single `done_o`.
- R12: Once `bus_req_o` is raised, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` stay stable and the request stays high until `bus_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a verify run when idle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| prot_o | output | 1 | Sector reported protected |
| err_o | output | 1 | Status byte was neither 0x00 nor 0x01 |
| hv_en_o | output | 1 | Enable for the high-voltage level on the flash reset pin |
| bus_req_o | output | 1 | Bus operation request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Bus operation complete |
| bus_rdata_i | input | 8 | Read data, valid with `bus_ack_i` on a read |

## Verification
The assertions assume that the bus agent raises `bus_ack_i` only while a request is pending, for a single cycle per operation, and that read data is valid in that cycle. The bench's bus model meets this: it waits until it sees `bus_req_o`, holds acknowledge for exactly one clock after a chosen latency, and drives `bus_rdata_i` only together with it. `start_i` is kept free of any assumption. The bench drives it as a one-cycle pulse, including while a run is in progress.

// File: rtl/otpv_pkg.sv
package otpv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_WR_ENTRY,
    S_WR_VERIFY,
    S_RD_STATUS,
    S_WR_RESET
  } seq_state_e;

  localparam logic [7:0] CMD_ENTRY  = 8'h60;
  localparam logic [7:0] CMD_VERIFY = 8'h40;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] STAT_OPEN  = 8'h00;
  localparam logic [7:0] STAT_LOCK  = 8'h01;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  p_cnt_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/status_decode.sv
module status_decode
  import otpv_pkg::*;
(
  input  logic [7:0] stat_i,
  output logic       prot_o,
  output logic       err_o
);
  always_comb begin
    prot_o = (stat_i == STAT_LOCK);
    err_o  = (stat_i != STAT_LOCK) && (stat_i != STAT_OPEN);
  end
endmodule

// File: rtl/otp_guard_verify.sv
module otp_guard_verify
  import otpv_pkg::*;
#(
  parameter int unsigned    AW          = 12,
  parameter int unsigned    WAIT_CYCLES = 200,
  parameter logic [AW-1:0]  CMD_ADDR    = 12'h555,
  parameter logic [AW-1:0]  SEC_ADDR    = 12'hAC5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          prot_o,
  output logic          err_o,
  output logic          hv_en_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [7:0]    bus_rdata_i
);
  // verify address: A6=0, A1=1, A0=0
  localparam logic [AW-1:0] CLR_MASK    = AW'(12'h041);
  localparam logic [AW-1:0] SET_MASK    = AW'(12'h002);
  localparam logic [AW-1:0] VERIFY_ADDR = (SEC_ADDR & ~CLR_MASK) | SET_MASK;

  seq_state_e state_q, state_d;
  logic hv_q, done_q, prot_q, err_q;
  logic kick, settled, dec_prot, dec_err, rd_done;

  assign kick    = (state_q == S_IDLE) && start_i;
  assign rd_done = (state_q == S_RD_STATUS) && bus_ack_i;

  settle_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (kick),
    .expired_o(settled)
  );

  status_decode u_dec (
    .stat_i(bus_rdata_i),
    .prot_o(dec_prot),
    .err_o (dec_err)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_i)   state_d = S_WAIT;
      S_WAIT:      if (settled)   state_d = S_WR_ENTRY;
      S_WR_ENTRY:  if (bus_ack_i) state_d = S_WR_VERIFY;
      S_WR_VERIFY: if (bus_ack_i) state_d = S_RD_STATUS;
      S_RD_STATUS: if (bus_ack_i) state_d = S_WR_RESET;
      S_WR_RESET:  if (bus_ack_i) state_d = S_IDLE;
      default:                    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hv_q    <= 1'b0;
      done_q  <= 1'b0;
      prot_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_WR_RESET) && bus_ack_i;
      if (kick) begin
        hv_q   <= 1'b1;
        prot_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (rd_done) begin
        hv_q   <= 1'b0;  // drop HV before the reset command goes out
        prot_q <= dec_prot;
        err_q  <= dec_err;
      end
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_addr_o  = CMD_ADDR;
    bus_wdata_o = 8'h00;
    unique case (state_q)
      S_WR_ENTRY:  bus_wdata_o = CMD_ENTRY;
      S_WR_VERIFY: begin
        bus_addr_o  = VERIFY_ADDR;
        bus_wdata_o = CMD_VERIFY;
      end
      S_RD_STATUS: begin
        bus_we_o   = 1'b0;
        bus_addr_o = VERIFY_ADDR;
      end
      S_WR_RESET:  bus_wdata_o = CMD_RESET;
      default:     bus_req_o = 1'b0;
    endcase
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign prot_o  = prot_q;
  assign err_o   = err_q;
  assign hv_en_o = hv_q;

  // cycles spent with HV applied, saturating at WAIT_CYCLES
  localparam int unsigned HW = $clog2(WAIT_CYCLES + 1) + 1;
  logic [HW-1:0] hv_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hv_age_q <= '0;
    else if (!hv_q)                     hv_age_q <= '0;
    else if (hv_age_q < HW'(WAIT_CYCLES)) hv_age_q <= hv_age_q + 1'b1;
  end

  p_settle_before_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && state_q == S_WR_ENTRY) |-> (hv_age_q >= HW'(WAIT_CYCLES)));
  p_hv_only_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> busy_o);
  p_reset_cmd_no_hv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_wdata_o == CMD_RESET) |-> !hv_en_o);
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o)
      && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_verdict_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prot_o && err_o));
  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != S_WAIT) |=> !$rose(hv_en_o));
endmodule

// File: tb/otp_guard_verify_tb_top.sv
module otp_guard_verify_tb_top;
  localparam int unsigned   AW    = 12;
  localparam int unsigned   WAIT  = 10;
  localparam logic [AW-1:0] CADDR = 12'h555;
  localparam logic [AW-1:0] SADDR = 12'hAC5;
  localparam logic [AW-1:0] VADDR = 12'hA86;  // AC5 with A6=0, A1=1, A0=0

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ack = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic busy, done, prot, err, hv, req, we;
  logic [AW-1:0] addr;
  logic [7:0] wdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  otp_guard_verify #(.AW(AW), .WAIT_CYCLES(WAIT), .CMD_ADDR(CADDR), .SEC_ADDR(SADDR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .prot_o(prot), .err_o(err), .hv_en_o(hv),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  // {status byte, ack latency, expected prot, expected err, poke start}
  localparam int NV = 6;
  localparam logic [14:0] VEC [NV] = '{
    {8'h01, 4'd0, 1'b1, 1'b0, 1'b0},
    {8'h00, 4'd2, 1'b0, 1'b0, 1'b0},
    {8'hFF, 4'd1, 1'b0, 1'b1, 1'b0},
    {8'h02, 4'd3, 1'b0, 1'b1, 1'b1},
    {8'h01, 4'd1, 1'b1, 1'b0, 1'b1},
    {8'h80, 4'd0, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic serve(input logic e_we, input logic [AW-1:0] e_addr, input logic [7:0] e_data,
                       input logic e_hv, input logic [7:0] rd, input int lat, input string tag);
    int guard = 0;
    while (!req && guard < 100) begin @(negedge clk); guard++; end
    check(req === 1'b1, tag, {31'd0, req}, 1);
    check(we === e_we && addr === e_addr, tag, {19'd0, we, addr}, {19'd0, e_we, e_addr});
    if (e_we) check(wdata === e_data, tag, {24'd0, wdata}, {24'd0, e_data});
    check(hv === e_hv, tag, {31'd0, hv}, {31'd0, e_hv});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(req && we === e_we && addr === e_addr && (!e_we || wdata === e_data),
            "R12 hold", {19'd0, we, addr}, {19'd0, e_we, e_addr});
    end
    ack = 1'b1;
    rdata = rd;
    @(negedge clk);
    ack = 1'b0;
    rdata = 8'h00;
  endtask

  task automatic run(input logic [7:0] st, input int lat, input logic e_prot, input logic e_err, input logic poke);
    int n_wait;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(hv && busy, "R2 hv/busy", {30'd0, hv, busy}, 3);
    check(!prot && !err, "R2 cleared", {30'd0, prot, err}, 0);
    n_wait = 0;
    while (!req && n_wait < 1000) begin
      if (!hv) break;
      n_wait++;
      if (poke && n_wait == 3) start = 1'b1;  // R11: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    check(n_wait == WAIT, "R3 settle", n_wait, WAIT);
    serve(1'b1, CADDR, 8'h60, 1'b1, 8'h00, lat, "R4 entry");
    serve(1'b1, VADDR, 8'h40, 1'b1, 8'h00, lat, "R5 verify");
    if (poke) start = 1'b1;  // R11: poke during the status read
    serve(1'b0, VADDR, 8'h00, 1'b1, st, lat, "R6 read");
    start = 1'b0;
    check(hv === 1'b0, "R9 hv drop", {31'd0, hv}, 0);
    serve(1'b1, CADDR, 8'hF0, 1'b0, 8'h00, lat, "R9 reset cmd");
    check(done && !busy, "R10 done", {30'd0, done, busy}, 2);
    check(prot === e_prot && err === e_err, e_err ? "R8 error" : "R7 verdict",
          {30'd0, prot, err}, {30'd0, e_prot, e_err});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!done && !busy && !req && !hv, "R11 single run", {28'd0, done, busy, req, hv}, 0);
      check(prot === e_prot && err === e_err, "R10 held", {30'd0, prot, err}, {30'd0, e_prot, e_err});
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !hv && !req && !prot && !err, "R1 reset",
          {26'd0, busy, done, hv, req, prot, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !req && !hv, "R1 idle", {29'd0, busy, req, hv}, 0);
    for (int v = 0; v < NV; v++)
      run(VEC[v][14:7], int'(VEC[v][6:3]), VEC[v][2], VEC[v][1], VEC[v][0]);
    // R11 directed: start held high through a whole run yields one run only
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check(busy && hv, "R11 start", {30'd0, busy, hv}, 3);
    serve(1'b1, CADDR, 8'h60, 1'b1, 8'h00, 0, "R11 entry");
    serve(1'b1, VADDR, 8'h40, 1'b1, 8'h00, 0, "R11 verify");
    serve(1'b0, VADDR, 8'h00, 1'b1, 8'h00, 0, "R11 read");
    start = 1'b0;
    serve(1'b1, CADDR, 8'hF0, 1'b0, 8'h00, 0, "R11 reset cmd");
    check(done && !prot && !err, "R7 open", {29'd0, done, prot, err}, 4);
    @(negedge clk);
    check(!busy && !done, "R11 end", {30'd0, busy, done}, 0);
    summary();
  end
endmodule